// File: doc/BRIEF.md
# Block-Floating-Point Complex Multiplier

This block multiplies two complex operands, X and Y. Each operand has a real part and an imaginary part, and each part is a 16-bit two's complement fraction. It is built for the butterfly datapath of a fast Fourier transform. Four fractional multipliers form the cross products. A subtracting adder builds the real part and an adding adder builds the imaginary part. A scaler follows the two adders and applies one shift, chosen by a word tag, to both parts.

A mode input selects the behaviour. With the mode low, results pass through unscaled and are clamped to 32 bits. With the mode high, the tag shift is applied and a 2-bit growth value is reported, so that an exponent tracker outside the block can follow the dynamic range. A combinational output select chooses which pair of 16-bit words from the two 32-bit results drives the two output ports.

Top module: `bfp_cmul`

## Requirements
- R1: While reset is asserted, and until the first operands have flowed through, `out_p_o`, `out_q_o` and `grow_o` are all zero.
- R2: `xr_i`/`xi_i` are captured only on clock edges with `ce_x_i` high, and `yr_i`/`yi_i` only on edges with `ce_y_i` high. Otherwise the previously captured operand is reused.
- R3: A result appears on the outputs three clock edges after the edge that captures its operands. That is the fourth edge counted from the capture edge.
- R4: Each fractional product is 2·a·b taken as a 32-bit value. The real result is XR·YR − XI·YI and the imaginary result is XR·YI + XI·YR. Both are formed at 33 bits before scaling.
- R5: A multiplier that sees −1 × −1 (both operands 0x8000) yields 0x7FFFFFFF in place of the unrepresentable +1.
- R6: With the mode low, each 33-bit sum is clamped to the signed 32-bit range without shifting, and `grow_o` is 0.
- R7: With the mode high, the tag scales both parts. Tag 00 leaves them unchanged, 01 shifts right by 1, 10 shifts right by 2, and 11 shifts left by 1. Right shifts are arithmetic, and the left-shifted value is clamped to the signed 32-bit range.
- R8: With the mode high, each part's growth is 2 if its 33-bit sum does not fit in 32 bits. It is 1 if the sum fits but bits 31 and 30 differ, and 0 otherwise. `grow_o` is the larger of the two part values and is never 3.
- R9: `osel_i` acts in the same cycle. 00 gives real[31:16]/imag[31:16], 01 gives real[15:0]/imag[15:0], 10 gives real[31:16]/real[15:0], and 11 gives imag[31:16]/imag[15:0] on `out_p_o`/`out_q_o`.
- R10: The mode and tag are sampled on every edge, on the same edge as the operand capture, whatever the enables are. They travel with that edge's operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 1 = block floating point, 0 = normal |
| ce_x_i | input | 1 | Capture enable for X |
| ce_y_i | input | 1 | Capture enable for Y |
| xr_i | input | 16 | X real part |
| xi_i | input | 16 | X imaginary part |
| yr_i | input | 16 | Y real part |
| yi_i | input | 16 | Y imaginary part |
| tag_i | input | 2 | Word-tag scale select |
| osel_i | input | 2 | Output word-pair select, combinational |
| out_p_o | output | 16 | First output word |
| out_q_o | output | 16 | Second output word |
| grow_o | output | 2 | Growth indication in block floating point mode |

## Verification
Two functions can act on the same result. The −1 × −1 trap in a multiplier can fall in the same cycle as clamping and growth in the scaler. For example, XR = YR = XI = 0x8000 with YI = 0x7FFF drives the trapped product straight into a real sum that overflows 32 bits, and a left-shift tag then has to clamp it. The sweep provokes such cases by crossing every corner fraction on all four operand parts with every tag in both modes, while toggling the capture enables. Each output word pair is then compared against an arithmetic model of the trap, the 33-bit sums, the shift, the clamp and the growth rule.

// File: rtl/bfp_cmul_pkg.sv
package bfp_cmul_pkg;

  // Post-add scaling selected by the word tag
  typedef enum logic [1:0] {
    SH_NONE   = 2'b00,
    SH_RIGHT1 = 2'b01,
    SH_RIGHT2 = 2'b10,
    SH_LEFT1  = 2'b11
  } scale_e;

  // Output word-pair routing
  typedef enum logic [1:0] {
    SEL_HIGHS = 2'b00,
    SEL_LOWS  = 2'b01,
    SEL_REAL  = 2'b10,
    SEL_IMAG  = 2'b11
  } outsel_e;

  // Control that travels down the pipe with each operand set
  typedef struct packed {
    logic   bfp;
    scale_e tag;
  } ctl_t;

endpackage

// File: rtl/bfp_frac_mult.sv
module bfp_frac_mult #(
  parameter int W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic signed [W-1:0]   a_i,
  input  logic signed [W-1:0]   b_i,
  output logic signed [2*W-1:0] p_o
);
  localparam int PW = 2 * W;
  localparam logic signed [W-1:0]  MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [PW-1:0] MOST_POS = {1'b0, {(PW-1){1'b1}}};

  logic signed [PW-1:0] full;
  logic                 trap;
  logic signed [PW-1:0] p_d;

  always_comb begin
    full = PW'(a_i) * PW'(b_i);
    trap = (a_i == MOST_NEG) && (b_i == MOST_NEG);
    p_d  = trap ? MOST_POS : (full <<< 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) p_o <= '0;
    else        p_o <= p_d;
  end
endmodule

// File: rtl/bfp_addsub.sv
module bfp_addsub #(
  parameter int PW  = 32,
  parameter bit SUB = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic signed [PW-1:0] a_i,
  input  logic signed [PW-1:0] b_i,
  output logic signed [PW:0]   s_o
);
  logic signed [PW:0] a_x;
  logic signed [PW:0] b_x;
  logic signed [PW:0] s_d;

  always_comb begin
    a_x = {a_i[PW-1], a_i};
    b_x = {b_i[PW-1], b_i};
  end

  generate
    if (SUB) begin : g_sub
      always_comb s_d = a_x - b_x;
    end else begin : g_add
      always_comb s_d = a_x + b_x;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_o <= '0;
    else        s_o <= s_d;
  end
endmodule

// File: rtl/bfp_scaler.sv
module bfp_scaler
  import bfp_cmul_pkg::*;
#(
  parameter int PW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [PW:0]   s_i,
  input  ctl_t                 ctl_i,
  output logic signed [PW-1:0] r_o,
  output logic [1:0]           g_o
);
  localparam int EW = PW + 3;
  localparam int TW = EW - PW + 1;

  logic signed [EW-1:0] ext;
  logic signed [EW-1:0] shf;
  logic [TW-1:0]        top;
  logic signed [PW-1:0] r_d;
  logic [1:0]           g_d;

  always_comb begin
    ext = {{2{s_i[PW]}}, s_i};
    shf = ext;
    if (ctl_i.bfp) begin
      case (ctl_i.tag)
        SH_RIGHT1: shf = ext >>> 1;
        SH_RIGHT2: shf = ext >>> 2;
        SH_LEFT1:  shf = ext <<< 1;
        default:   shf = ext;
      endcase
    end
    top = shf[EW-1:PW-1];
    if ((&top) || !(|top))  r_d = shf[PW-1:0];
    else if (shf[EW-1])     r_d = {1'b1, {(PW-1){1'b0}}};
    else                    r_d = {1'b0, {(PW-1){1'b1}}};

    g_d = 2'd0;
    if (ctl_i.bfp) begin
      if (s_i[PW] != s_i[PW-1])        g_d = 2'd2;
      else if (s_i[PW-1] != s_i[PW-2]) g_d = 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_o <= '0;
      g_o <= '0;
    end else begin
      r_o <= r_d;
      g_o <= g_d;
    end
  end
endmodule

// File: rtl/bfp_cmul.sv
module bfp_cmul
  import bfp_cmul_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_i,
  input  logic         ce_x_i,
  input  logic         ce_y_i,
  input  logic [W-1:0] xr_i,
  input  logic [W-1:0] xi_i,
  input  logic [W-1:0] yr_i,
  input  logic [W-1:0] yi_i,
  input  logic [1:0]   tag_i,
  input  logic [1:0]   osel_i,
  output logic [W-1:0] out_p_o,
  output logic [W-1:0] out_q_o,
  output logic [1:0]   grow_o
);
  localparam int PW     = 2 * W;
  localparam int NMUL   = 4;
  localparam int NPART  = 2;
  localparam int CDEPTH = 3;

  // reset: asynchronous assert, synchronous release
  logic rs_meta;
  logic rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rst_q_n <= rs_meta;
    end
  end

  // operand capture with enables
  logic signed [W-1:0] xr_q, xi_q, yr_q, yi_q;
  logic signed [W-1:0] xr_d, xi_d, yr_d, yi_d;

  always_comb begin
    xr_d = ce_x_i ? xr_i : xr_q;
    xi_d = ce_x_i ? xi_i : xi_q;
    yr_d = ce_y_i ? yr_i : yr_q;
    yi_d = ce_y_i ? yi_i : yi_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      xr_q <= '0;
      xi_q <= '0;
      yr_q <= '0;
      yi_q <= '0;
    end else begin
      xr_q <= xr_d;
      xi_q <= xi_d;
      yr_q <= yr_d;
      yi_q <= yi_d;
    end
  end

  // control pipe, sampled every edge alongside the operands
  ctl_t ctl_pipe [CDEPTH];
  ctl_t ctl_in;

  always_comb begin
    ctl_in.bfp = mode_i;
    ctl_in.tag = scale_e'(tag_i);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      for (int i = 0; i < CDEPTH; i++) ctl_pipe[i] <= '0;
    end else begin
      ctl_pipe[0] <= ctl_in;
      for (int i = 1; i < CDEPTH; i++) ctl_pipe[i] <= ctl_pipe[i-1];
    end
  end

  // partial products: rr, ii, ri, ir
  logic signed [W-1:0]  op_a [NMUL];
  logic signed [W-1:0]  op_b [NMUL];
  logic signed [PW-1:0] prod [NMUL];

  always_comb begin
    op_a[0] = xr_q; op_b[0] = yr_q;
    op_a[1] = xi_q; op_b[1] = yi_q;
    op_a[2] = xr_q; op_b[2] = yi_q;
    op_a[3] = xi_q; op_b[3] = yr_q;
  end

  generate
    for (genvar m = 0; m < NMUL; m++) begin : g_mul
      bfp_frac_mult #(.W(W)) u_mul (
        .clk   (clk),
        .rst_n (rst_q_n),
        .a_i   (op_a[m]),
        .b_i   (op_b[m]),
        .p_o   (prod[m])
      );
    end
  endgenerate

  // part 0 = real (subtract), part 1 = imaginary (add)
  logic signed [PW:0]   sums  [NPART];
  logic signed [PW-1:0] res   [NPART];
  logic [1:0]           gpart [NPART];

  generate
    for (genvar k = 0; k < NPART; k++) begin : g_part
      bfp_addsub #(.PW(PW), .SUB(k == 0)) u_as (
        .clk   (clk),
        .rst_n (rst_q_n),
        .a_i   (prod[2*k]),
        .b_i   (prod[2*k+1]),
        .s_o   (sums[k])
      );
      bfp_scaler #(.PW(PW)) u_sc (
        .clk   (clk),
        .rst_n (rst_q_n),
        .s_i   (sums[k]),
        .ctl_i (ctl_pipe[CDEPTH-1]),
        .r_o   (res[k]),
        .g_o   (gpart[k])
      );
    end
  endgenerate

  // output routing, combinational on the select
  always_comb begin
    grow_o = (gpart[0] > gpart[1]) ? gpart[0] : gpart[1];
    case (outsel_e'(osel_i))
      SEL_HIGHS: begin out_p_o = res[0][PW-1:W]; out_q_o = res[1][PW-1:W]; end
      SEL_LOWS:  begin out_p_o = res[0][W-1:0];  out_q_o = res[1][W-1:0];  end
      SEL_REAL:  begin out_p_o = res[0][PW-1:W]; out_q_o = res[0][W-1:0];  end
      default:   begin out_p_o = res[1][PW-1:W]; out_q_o = res[1][W-1:0];  end
    endcase
  end
endmodule

// File: rtl/bfp_cmul_chk.sv
module bfp_cmul_chk #(
  parameter int W = 16
) (
  input logic                  clk,
  input logic                  rst_q_n,
  input logic                  ce_x,
  input logic                  ce_y,
  input logic signed [W-1:0]   xr_q,
  input logic signed [W-1:0]   xi_q,
  input logic signed [W-1:0]   yr_q,
  input logic signed [W-1:0]   yi_q,
  input logic signed [2*W-1:0] p_rr,
  input logic signed [2*W-1:0] p_ii,
  input logic                  bfp_s2,
  input logic [1:0]            grow
);
  localparam logic signed [W-1:0]   NEG1 = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [2*W-1:0] TOP  = {1'b0, {(2*W-1){1'b1}}};

  // R2
  hold_x_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !ce_x |=> ($stable(xr_q) && $stable(xi_q)));

  // R2
  hold_y_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !ce_y |=> ($stable(yr_q) && $stable(yi_q)));

  // R5
  trap_rr_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (xr_q == NEG1 && yr_q == NEG1) |=> (p_rr == TOP));

  // R5
  trap_ii_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (xi_q == NEG1 && yi_q == NEG1) |=> (p_ii == TOP));

  // R6
  normal_grow_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !bfp_s2 |=> (grow == 2'd0));

  // R8
  grow_range_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    grow != 2'b11);
endmodule

bind bfp_cmul bfp_cmul_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_q_n (rst_q_n),
  .ce_x    (ce_x_i),
  .ce_y    (ce_y_i),
  .xr_q    (xr_q),
  .xi_q    (xi_q),
  .yr_q    (yr_q),
  .yi_q    (yi_q),
  .p_rr    (prod[0]),
  .p_ii    (prod[1]),
  .bfp_s2  (ctl_pipe[2].bfp),
  .grow    (grow_o)
);

// File: tb/sim_bfp_cmul.sv
`timescale 1ns/1ps
module sim_bfp_cmul;
  logic        clk;
  logic        rst_n;
  logic        mode_i, ce_x_i, ce_y_i;
  logic [15:0] xr_i, xi_i, yr_i, yi_i;
  logic [1:0]  tag_i, osel_i;
  logic [15:0] out_p_o, out_q_o;
  logic [1:0]  grow_o;

  bfp_cmul u0 (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;
  string phase = "";

  int hxr = 0, hxi = 0, hyr = 0, hyi = 0;
  logic [31:0] q_re  [8];
  logic [31:0] q_im  [8];
  logic [1:0]  q_g   [8];
  string       q_tag [8];
  bit          q_v   [8];

  int vals [8] = '{-32768, -32767, -16384, -1, 0, 1, 16384, 32767};

  function automatic longint fprod(int a, int b);
    if (a == -32768 && b == -32768) return 64'sd2147483647;
    return longint'(a) * longint'(b) * 2;
  endfunction

  function automatic longint sat32(longint v);
    if (v > 64'sd2147483647)  return 64'sd2147483647;
    if (v < -64'sd2147483648) return -64'sd2147483648;
    return v;
  endfunction

  function automatic longint scale(longint s, bit m, int t);
    if (!m) return sat32(s);
    case (t)
      1:       return sat32(s >>> 1);
      2:       return sat32(s >>> 2);
      3:       return sat32(s * 2);
      default: return sat32(s);
    endcase
  endfunction

  function automatic int growth(longint s);
    if (s > 64'sd2147483647 || s < -64'sd2147483648) return 2;
    if (s >= 64'sd1073741824 || s < -64'sd1073741824) return 1;
    return 0;
  endfunction

  task automatic check_words(logic [31:0] re, logic [31:0] im, logic [1:0] g, string tag);
    logic [15:0] ep, eq;
    case (osel_i)
      2'b00:   begin ep = re[31:16]; eq = im[31:16]; end
      2'b01:   begin ep = re[15:0];  eq = im[15:0];  end
      2'b10:   begin ep = re[31:16]; eq = re[15:0];  end
      default: begin ep = im[31:16]; eq = im[15:0];  end
    endcase
    checks++;
    if (out_p_o !== ep || out_q_o !== eq) begin
      errors++;
      $display("FAIL %s R9 cyc %0d osel %0d: got %h/%h expected %h/%h",
               tag, cyc, osel_i, out_p_o, out_q_o, ep, eq);
    end
    checks++;
    if (grow_o !== g) begin
      errors++;
      $display("FAIL R8 %s cyc %0d: grow got %0d expected %0d", tag, cyc, grow_o, g);
    end
  endtask

  // one cycle: check the result captured four negedges earlier, then drive
  task automatic step(bit m, int t, int a, int b, int c, int d, bit cx, bit cy);
    int slot, old;
    longint sr, si;
    @(negedge clk);
    osel_i = 2'(cyc);
    #0.5;
    old = (cyc + 4) % 8;
    if (q_v[old]) begin
      check_words(q_re[old], q_im[old], q_g[old], q_tag[old]);
      q_v[old] = 0;
    end
    mode_i = m; tag_i = 2'(t); ce_x_i = cx; ce_y_i = cy;
    xr_i = 16'(a); xi_i = 16'(b); yr_i = 16'(c); yi_i = 16'(d);
    // R2 hold model, R10 control sampled regardless of enables
    if (cx) begin hxr = a; hxi = b; end
    if (cy) begin hyr = c; hyi = d; end
    sr = fprod(hxr, hyr) - fprod(hxi, hyi);
    si = fprod(hxr, hyi) + fprod(hxi, hyr);
    slot = cyc % 8;
    q_re[slot] = 32'(scale(sr, m, t));
    q_im[slot] = 32'(scale(si, m, t));
    q_g[slot]  = m ? 2'((growth(sr) > growth(si)) ? growth(sr) : growth(si)) : 2'd0;
    if (phase != "")                                       q_tag[slot] = phase;
    else if (!cx || !cy)                                   q_tag[slot] = "R2 R10 R4";
    else if ((hxr == -32768 && hyr == -32768) ||
             (hxi == -32768 && hyi == -32768) ||
             (hxr == -32768 && hyi == -32768) ||
             (hxi == -32768 && hyr == -32768))             q_tag[slot] = "R5 R4";
    else if (m)                                            q_tag[slot] = "R7 R4";
    else                                                   q_tag[slot] = "R6 R4";
    q_v[slot] = 1;
    cyc++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at cyc %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) q_v[i] = 0;
    rst_n = 1'b0; mode_i = 0; ce_x_i = 0; ce_y_i = 0;
    xr_i = '0; xi_i = '0; yr_i = '0; yi_i = '0; tag_i = '0; osel_i = '0;

    // R1: outputs zero while reset is held
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      osel_i = 2'(i);
      xr_i = 16'h7fff; yr_i = 16'h7fff; ce_x_i = 1; ce_y_i = 1; mode_i = 1;
      #0.5;
      checks++;
      if (out_p_o !== 16'h0 || out_q_o !== 16'h0 || grow_o !== 2'd0) begin
        errors++;
        $display("FAIL R1 reset: got %h/%h/%0d expected 0000/0000/0", out_p_o, out_q_o, grow_o);
      end
    end
    @(negedge clk);
    xr_i = '0; yr_i = '0; ce_x_i = 0; ce_y_i = 0; mode_i = 0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #0.5;
    checks++;
    if (out_p_o !== 16'h0 || out_q_o !== 16'h0 || grow_o !== 2'd0) begin
      errors++;
      $display("FAIL R1 after release: got %h/%h/%0d expected 0000/0000/0", out_p_o, out_q_o, grow_o);
    end

    // R3: a single impulse, zeros around it, checked at exact cycles
    phase = "R3";
    step(0, 0, 0, 0, 0, 0, 1, 1);
    step(1, 0, 16384, 0, 16384, 0, 1, 1);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 0, 1, 1);
    phase = "";

    // sweep of corner fractions over both modes and all tags
    for (int m = 0; m < 2; m++)
      for (int t = 0; t < 4; t++)
        for (int a = 0; a < 8; a++)
          for (int b = 0; b < 8; b++)
            for (int c = 0; c < 8; c++)
              for (int d = 0; d < 8; d++)
                step(bit'(m), t, vals[a], vals[b], vals[c], vals[d],
                     (cyc % 7) != 3, (cyc % 5) != 2);

    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, 0, 1, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule